// File: doc/BRIEF.md
# Keyed Configuration Port Register File

This block is a small I/O-mapped configuration space reached through a byte-wide index/data port pair on a host bus. It stays locked after reset and only opens once the host writes a four-byte key to the index port. After that the host selects a register number through the index port and then reads or writes the selected register through the data port at the next address. The space holds a read-only chip identity, a logical-device selector, a global flash-control register and a 16-bit flash-controller port base, and the last two drive output pins.

A strap input chooses between two base addresses, and the last key byte depends on that choice. A specific write to the exit register locks the space again. The flash base is banked behind the logical-device selector: it is visible and writable only while the flash logical device is selected.

Top module: `keyed_cfg_space`

## Requirements
- R1: A synchronous active-high reset leaves the block locked (`cfg_open` = 0), `flash_base` = 0x0000 and `flash_ctrl` = 0x00, with the data port reading 0xFF.
- R2: With `strap_alt` = 0 the index port is 0x002E and the data port 0x002F; with `strap_alt` = 1 they are 0x004E and 0x004F. Writing 0x87, 0x01, 0x55 and a final byte to the index port in that order opens the block in the cycle after the final write; the final byte is 0x55 for `strap_alt` = 0 and 0xAA for `strap_alt` = 1. Key bytes sent to the other base have no effect.
- R3: A wrong byte at any key position returns the unlock sequence to its start, except that a wrong byte equal to 0x87 counts as the first key byte of a new sequence.
- R4: While locked, every read returns 0xFF and writes to the data port change neither `flash_base` nor `flash_ctrl`.
- R5: While open, a write to the index port selects a register, and data-port accesses address that register. Register 0x20 reads 0x87 and register 0x21 reads 0x16; both ignore writes.
- R6: Writing 0x02 to register 0x02 locks the block from the next cycle; any other value written there leaves it open.
- R7: Register 0x07 is a read/write logical-device selector. Only while it holds 0x07 do registers 0x64 (high byte) and 0x65 (low byte) read and write `flash_base`; otherwise they read 0x00 and ignore writes.
- R8: Register 0x24 is the flash-control byte driven on `flash_ctrl`: bit 0 suspend, bits 1 to 3 segment decode enables, bit 4 host write enable, bit 5 alternate pin select. Bits 7:6 are always 0 and ignore writes.
- R9: While open, any register number not listed above reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Base select: 0 = primary, 1 = alternate (static) |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0xFF when not driven by a register |
| cfg_open | output | 1 | High while configuration access is unlocked |
| flash_base | output | 16 | Flash-controller port base |
| flash_ctrl | output | 8 | Global flash-control byte |

## Verification
The bench uses the default 16-bit address and the two default base addresses and repeats every test for both strap settings. Because the register bytes are only eight bits wide, it sweeps all 256 values for a wrong byte at each of the four key positions, and all 256 values through the flash-control register, so the whole key comparison and the reserved-bit masking are covered rather than sampled. Directed sequences cover the restart on 0x87, the foreign base, the banked flash base and both outcomes of the exit write.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] KEY_FIRST    = 8'h87;
    localparam logic [7:0] KEY_SECOND   = 8'h01;
    localparam logic [7:0] KEY_THIRD    = 8'h55;
    localparam logic [7:0] KEY_LAST_PRI = 8'h55;
    localparam logic [7:0] KEY_LAST_ALT = 8'hAA;

    localparam logic [7:0] REG_EXIT   = 8'h02;
    localparam logic [7:0] REG_LDN    = 8'h07;
    localparam logic [7:0] REG_ID_HI  = 8'h20;
    localparam logic [7:0] REG_ID_LO  = 8'h21;
    localparam logic [7:0] REG_FCTL   = 8'h24;
    localparam logic [7:0] REG_FB_HI  = 8'h64;
    localparam logic [7:0] REG_FB_LO  = 8'h65;

    localparam logic [7:0]  EXIT_CODE = 8'h02;
    localparam logic [7:0]  LDN_FLASH = 8'h07;
    localparam logic [15:0] CHIP_ID   = 16'h8716;
    localparam logic [7:0]  FCTL_MASK = 8'h3F;
    localparam logic [7:0]  IDLE_BUS  = 8'hFF;

    typedef enum logic [2:0] {
        KEY_IDLE = 3'd0,
        KEY_B1   = 3'd1,
        KEY_B2   = 3'd2,
        KEY_B3   = 3'd3,
        KEY_OPEN = 3'd4
    } key_state_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             at_index;
        logic             at_data;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [7:0] key_byte(input logic [1:0] pos, input logic alt);
        case (pos)
            2'd0:    key_byte = KEY_FIRST;
            2'd1:    key_byte = KEY_SECOND;
            2'd2:    key_byte = KEY_THIRD;
            default: key_byte = alt ? KEY_LAST_ALT : KEY_LAST_PRI;
        endcase
    endfunction

endpackage

// File: rtl/keyed_cfg_decode.sv
module keyed_cfg_decode
    import keyed_cfg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output bus_req_t          req
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] base_sel;

    always_comb begin
        base_sel     = strap_alt ? BASE_ALT : BASE_PRI;
        req.wr       = bus_wr;
        req.rd       = bus_rd;
        req.at_index = (bus_addr == base_sel);
        req.at_data  = (bus_addr == base_sel + ONE);
        req.wdata    = bus_wdata;
    end
endmodule

// File: rtl/keyed_cfg_unlock.sv
module keyed_cfg_unlock
    import keyed_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strap_alt,
    input  bus_req_t req,
    input  logic     relock,
    output logic     open
);
    key_state_t state_q, state_d;
    logic [7:0] expect_byte;

    always_comb begin
        expect_byte = key_byte(state_q[1:0], strap_alt);
        state_d     = state_q;
        if (state_q == KEY_OPEN) begin
            if (relock)
                state_d = KEY_IDLE;
        end else if (req.wr && req.at_index) begin
            if (req.wdata == expect_byte)
                state_d = key_state_t'(state_q + 3'd1);
            else if (req.wdata == KEY_FIRST)
                state_d = KEY_B1;
            else
                state_d = KEY_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= KEY_IDLE;
        else
            state_q <= state_d;
    end

    assign open = (state_q == KEY_OPEN);
endmodule

// File: rtl/keyed_cfg_regs.sv
module keyed_cfg_regs
    import keyed_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        open,
    input  bus_req_t    req,
    output logic        relock,
    output logic [7:0]  reg_index,
    output logic [7:0]  rdata,
    output logic [15:0] flash_base,
    output logic [7:0]  flash_ctrl
);
    logic [7:0]  idx_q, ldn_q, fctl_q;
    logic [15:0] fbase_q;
    logic        idx_wr, data_wr, flash_bank;
    logic [7:0]  reg_val;

    assign idx_wr     = open && req.wr && req.at_index;
    assign data_wr    = open && req.wr && req.at_data;
    assign flash_bank = (ldn_q == LDN_FLASH);
    assign relock     = data_wr && (idx_q == REG_EXIT) && (req.wdata == EXIT_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            ldn_q   <= '0;
            fctl_q  <= '0;
            fbase_q <= '0;
        end else begin
            if (relock)
                idx_q <= '0;
            else if (idx_wr)
                idx_q <= req.wdata;
            if (data_wr) begin
                case (idx_q)
                    REG_LDN:  ldn_q  <= req.wdata;
                    REG_FCTL: fctl_q <= req.wdata & FCTL_MASK;
                    REG_FB_HI: if (flash_bank) fbase_q[15:8] <= req.wdata;
                    REG_FB_LO: if (flash_bank) fbase_q[7:0]  <= req.wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (idx_q)
            REG_ID_HI: reg_val = CHIP_ID[15:8];
            REG_ID_LO: reg_val = CHIP_ID[7:0];
            REG_LDN:   reg_val = ldn_q;
            REG_FCTL:  reg_val = fctl_q;
            REG_FB_HI: reg_val = flash_bank ? fbase_q[15:8] : 8'h00;
            REG_FB_LO: reg_val = flash_bank ? fbase_q[7:0]  : 8'h00;
            default:   reg_val = 8'h00;
        endcase
        if (!open || !req.rd)
            rdata = IDLE_BUS;
        else if (req.at_index)
            rdata = idx_q;
        else if (req.at_data)
            rdata = reg_val;
        else
            rdata = IDLE_BUS;
    end

    assign reg_index  = idx_q;
    assign flash_base = fbase_q;
    assign flash_ctrl = fctl_q;
endmodule

// File: rtl/keyed_cfg_space.sv
module keyed_cfg_space
    import keyed_cfg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cfg_open,
    output logic [15:0]       flash_base,
    output logic [7:0]        flash_ctrl
);
    bus_req_t   req;
    logic       relock;
    logic [7:0] reg_index;

    keyed_cfg_decode #(
        .ADDR_W  (ADDR_W),
        .BASE_PRI(BASE_PRI),
        .BASE_ALT(BASE_ALT)
    ) u_decode (
        .strap_alt(strap_alt),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .req      (req)
    );

    keyed_cfg_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .strap_alt(strap_alt),
        .req      (req),
        .relock   (relock),
        .open     (cfg_open)
    );

    keyed_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .open      (cfg_open),
        .req       (req),
        .relock    (relock),
        .reg_index (reg_index),
        .rdata     (bus_rdata),
        .flash_base(flash_base),
        .flash_ctrl(flash_ctrl)
    );
endmodule

// File: rtl/keyed_cfg_space_chk.sv
module keyed_cfg_space_chk #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
    input logic              clk,
    input logic              rst,
    input logic              strap_alt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cfg_open,
    input logic [7:0]        reg_index,
    input logic [15:0]       flash_base,
    input logic [7:0]        flash_ctrl
);
    logic [ADDR_W-1:0] idx_port, dat_port;
    logic [7:0]        last_key;

    assign idx_port = strap_alt ? BASE_ALT : BASE_PRI;
    assign dat_port = idx_port + ADDR_W'(1);
    assign last_key = strap_alt ? 8'hAA : 8'h55;

    AST_RESET_LOCKS: assert property (@(posedge clk)
        rst |=> (!cfg_open && flash_base == 16'h0000 && flash_ctrl == 8'h00)); // R1

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> ($past(bus_wr) && $past(bus_addr) == idx_port
                             && $past(bus_wdata) == last_key)); // R2

    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && bus_rd) |-> bus_rdata == 8'hFF); // R4

    AST_LOCKED_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |=> ($stable(flash_base) && $stable(flash_ctrl))); // R4

    AST_ID_HIGH_BYTE: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && bus_rd && bus_addr == dat_port && reg_index == 8'h20)
        |-> bus_rdata == 8'h87); // R5

    AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && bus_wr && bus_addr == dat_port && reg_index == 8'h02
         && bus_wdata == 8'h02) |=> !cfg_open); // R6

    AST_FCTL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && bus_wr && bus_addr == dat_port && reg_index == 8'h24)
        |=> flash_ctrl == ($past(bus_wdata) & 8'h3F)); // R8
endmodule

bind keyed_cfg_space keyed_cfg_space_chk #(
    .ADDR_W  (ADDR_W),
    .BASE_PRI(BASE_PRI),
    .BASE_ALT(BASE_ALT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strap_alt (strap_alt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_open  (cfg_open),
    .reg_index (reg_index),
    .flash_base(flash_base),
    .flash_ctrl(flash_ctrl)
);

// File: tb/keyed_cfg_space_test.sv
module keyed_cfg_space_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_alt = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cfg_open;
    logic [15:0] flash_base;
    logic [7:0]  flash_ctrl;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    keyed_cfg_space uut (
        .clk(clk), .rst(rst), .strap_alt(strap_alt), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_open(cfg_open),
        .flash_base(flash_base), .flash_ctrl(flash_ctrl)
    );

    task automatic check(input int actual, input int expected, input string req);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    function automatic logic [15:0] base_of(input logic s);
        return s ? 16'h004E : 16'h002E;
    endfunction

    function automatic logic [7:0] key_of(input int pos, input logic s);
        case (pos)
            0: return 8'h87;
            1: return 8'h01;
            2: return 8'h55;
            default: return s ? 8'hAA : 8'h55;
        endcase
    endfunction

    task automatic send_key(input logic [15:0] a, input logic s);
        for (int i = 0; i < 4; i++) bus_write(a, key_of(i, s));
    endtask

    task automatic reg_wr(input logic [15:0] b, input logic [7:0] r, input logic [7:0] d);
        bus_write(b, r);
        bus_write(b + 16'd1, d);
    endtask

    task automatic reg_rd(input logic [15:0] b, input logic [7:0] r, output logic [7:0] v);
        bus_write(b, r);
        bus_read(b + 16'd1, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] b;
        logic [15:0] exp_base;
        for (int s = 0; s < 2; s++) begin
            strap_alt = s[0];
            b = base_of(s[0]);
            do_reset();
            // R1 reset state
            check(cfg_open, 0, "R1");
            check(flash_base, 0, "R1");
            check(flash_ctrl, 0, "R1");
            bus_read(b + 16'd1, v);
            check(v, 8'hFF, "R1");
            // R4 locked data writes ignored
            bus_write(b + 16'd1, 8'h3F);
            check(flash_ctrl, 0, "R4");
            bus_read(b, v);
            check(v, 8'hFF, "R4");
            // R2 key at the other base does nothing
            send_key(base_of(~s[0]), s[0]);
            check(cfg_open, 0, "R2");
            // R2 key at own base opens
            send_key(b, s[0]);
            check(cfg_open, 1, "R2");
            // R5 chip ID, read-only
            reg_rd(b, 8'h20, v); check(v, 8'h87, "R5");
            reg_rd(b, 8'h21, v); check(v, 8'h16, "R5");
            reg_wr(b, 8'h20, 8'h00);
            reg_rd(b, 8'h20, v); check(v, 8'h87, "R5");
            reg_wr(b, 8'h21, 8'hFF);
            reg_rd(b, 8'h21, v); check(v, 8'h16, "R5");
            bus_read(b, v); check(v, 8'h21, "R5");
            // R9 unmapped registers
            reg_rd(b, 8'h30, v); check(v, 8'h00, "R9");
            reg_rd(b, 8'hF0, v); check(v, 8'h00, "R9");
            // R8 flash control sweep
            for (int d = 0; d < 256; d++) begin
                reg_wr(b, 8'h24, d[7:0]);
                check(flash_ctrl, d & 8'h3F, "R8");
                bus_read(b + 16'd1, v);
                check(v, d & 8'h3F, "R8");
            end
            // R7 banked flash base
            reg_wr(b, 8'h07, 8'h03);
            reg_rd(b, 8'h07, v); check(v, 8'h03, "R7");
            reg_wr(b, 8'h64, 8'hAB);
            reg_wr(b, 8'h65, 8'hCD);
            check(flash_base, 0, "R7");
            reg_rd(b, 8'h64, v); check(v, 8'h00, "R7");
            reg_wr(b, 8'h07, 8'h07);
            exp_base = 16'h0000;
            for (int k = 0; k < 8; k++) begin
                logic [7:0] hi, lo;
                hi = 8'(k * 37 + 8'h0A + s * 5);
                lo = 8'(k * 91 + 8'h33);
                reg_wr(b, 8'h64, hi);
                exp_base = {hi, exp_base[7:0]};
                check(flash_base, exp_base, "R7");
                reg_wr(b, 8'h65, lo);
                exp_base = {hi, lo};
                check(flash_base, exp_base, "R7");
                reg_rd(b, 8'h64, v); check(v, hi, "R7");
                reg_rd(b, 8'h65, v); check(v, lo, "R7");
            end
            // R6 exit register
            reg_wr(b, 8'h02, 8'h01);
            check(cfg_open, 1, "R6");
            reg_wr(b, 8'h02, 8'h02);
            check(cfg_open, 0, "R6");
            bus_read(b + 16'd1, v); check(v, 8'hFF, "R6");
            // R4 locked after exit: writes to base/control ignored
            bus_write(b + 16'd1, 8'h00);
            check(flash_base, exp_base, "R4");
            check(flash_ctrl, 8'h3F, "R4");
            // R3 directed restarts on 0x87
            do_reset();
            bus_write(b, 8'h87); bus_write(b, 8'h01); bus_write(b, 8'h87);
            bus_write(b, 8'h01); bus_write(b, 8'h55); bus_write(b, key_of(3, s[0]));
            check(cfg_open, 1, "R3");
            do_reset();
            bus_write(b, 8'h87); bus_write(b, 8'h87); bus_write(b, 8'h01);
            bus_write(b, 8'h55); bus_write(b, key_of(3, s[0]));
            check(cfg_open, 1, "R3");
            do_reset();
            bus_write(b, 8'h87); bus_write(b, 8'h01); bus_write(b, 8'h00);
            bus_write(b, 8'h55); bus_write(b, key_of(3, s[0]));
            check(cfg_open, 0, "R3");
            // R3 sweep: one byte at every key position
            for (int p = 0; p < 4; p++) begin
                for (int d = 0; d < 256; d++) begin
                    do_reset();
                    for (int i = 0; i < p; i++) bus_write(b, key_of(i, s[0]));
                    bus_write(b, d[7:0]);
                    check(cfg_open, (p == 3 && d[7:0] == key_of(3, s[0])) ? 1 : 0, "R3");
                end
            end
        end
        summary();
    end
endmodule